// File: doc/BRIEF.md
# Wired-AND Programmable Interconnect Crossbar

This block is the global routing fabric between signal sources and a set of logic blocks. Three groups of sources feed it: macrocell outputs, I/O pin inputs and dedicated input pins. It drives a fixed number of inputs into each logic block, by default 24 inputs into each of four blocks. Any source can be connected to any crossbar output. A configuration bit at every source/output crossing selects the connection, so no routing pattern is ever blocked.

When several sources are connected to one output, the block does not treat them as conflicting drivers. They merge as a wide AND, which gives a free level of logic inside the routing. Each source also has a configurable invert bit, applied before the merge. With it the same AND can act as a wide NOR, or as a NAND or OR once the receiving block picks its own polarity. An output with nothing connected rests at logic 1, the identity of AND.

The data path is purely combinational and has the same depth for every connection pattern. The only clocked part is the configuration store. It is filled serially, one bit per clock while a load enable is high. The new pattern replaces the working one only when the last bit of a full frame has been accepted.

Top module: `wired_and_xbar`

## Requirements
- R1: While reset is asserted and after it is released, every crossing and every invert bit is cleared, so every output reads 1 whatever the sources are.
- R2: Each output equals the AND of the polarity-adjusted values of the sources connected to it. An output with no connected source reads 1.
- R3: Every source can be routed to every output. A single connection with its invert bit clear makes the output follow that source.
- R4: When a source's invert bit is 1, its value is complemented before the AND. Connecting all sources with all invert bits set yields a wide NOR: the output is 1 only when every source is 0.
- R5: The source index is fixed: macrocell outputs take indices 0 to NUM_MC-1, I/O inputs follow, and dedicated inputs come last. Output index o is block o / BLK_IN, input o % BLK_IN. A frame holds NUM_SRC invert bits, stream positions 0..NUM_SRC-1 for source 0 upward. These are followed by the crossing bits at position NUM_SRC + o*NUM_SRC + s for output o and source s. A 1 means connected or inverted.
- R6: One frame bit is accepted per clock while cfg_load_en is 1. Until the final bit of the frame is accepted, the outputs keep following the previous configuration. The new configuration governs the outputs from the clock edge that accepts the final bit.
- R7: While cfg_load_en is 0, cfg_bit is ignored. The working configuration and the position reached in a partly loaded frame are both kept, and a later load continues from that position.
- R8: Outputs respond to source changes with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load_en | input | 1 | Accept one frame bit on this clock edge |
| cfg_bit | input | 1 | Serial configuration data |
| mc_i | input | NUM_MC | Macrocell output sources |
| io_i | input | NUM_IO | I/O pin input sources |
| ded_i | input | NUM_DED | Dedicated input pin sources |
| blk_in_o | output | NUM_BLK*BLK_IN | Crossbar outputs, block-major |

## Verification
The bench uses a reduced fabric of seven sources and six outputs. Every one of the 128 source patterns is applied under each configuration and compared with an arithmetic model.

Several kinds of configuration are swept, and each separates a different fault:
- The reset configuration shows that an empty lane reads 1.
- Seven rotated single-connection maps cover every source/output pair, which exposes any slip in frame layout or source ordering.
- Pseudo-random dense maps with mixed invert bits test the AND merge across group boundaries of the two-level tree.
- A fully connected, fully inverted lane shows the NOR form.

Loads that stop one bit short, or that pause in the middle with cfg_bit toggling, show that a configuration takes effect only at the final bit.

// File: rtl/wxb_pkg.sv
package wxb_pkg;

   // Number of invert bits carried at the head of a configuration frame.
   function automatic int unsigned inv_bit_count(input int unsigned nsrc, input bit inv_en);
      return inv_en ? nsrc : 0;
   endfunction

   // Full frame length: optional invert bits plus one bit per crossing.
   function automatic int unsigned frame_len(input int unsigned nsrc,
                                             input int unsigned nout,
                                             input bit inv_en);
      return inv_bit_count(nsrc, inv_en) + nsrc * nout;
   endfunction

   // Counter width able to index every frame position.
   function automatic int unsigned ptr_width(input int unsigned len);
      return (len > 2) ? $clog2(len) : 1;
   endfunction

endpackage

// File: rtl/wxb_cfg_loader.sv
module wxb_cfg_loader #(
   parameter int unsigned TOTAL = 64,
   parameter int unsigned CW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic             cfg_bit,
   output logic [TOTAL-1:0] cfg_q,
   output logic [CW-1:0]    ptr_q
);

   localparam logic [CW-1:0] LAST_POS = CW'(TOTAL - 1);

   logic [TOTAL-1:0] shadow_q;
   logic [TOTAL-1:0] shadow_nxt;
   logic             at_last;

   generate
      if (TOTAL < 2) begin : g_bad_len
         $error("wxb_cfg_loader: frame must hold at least two bits");
      end
      if ((2 ** CW) < TOTAL) begin : g_bad_cw
         $error("wxb_cfg_loader: pointer too narrow for frame");
      end
   endgenerate

   // New bits enter at the top and walk down, so the first bit sent ends at index 0.
   assign shadow_nxt = {cfg_bit, shadow_q[TOTAL-1:1]};
   assign at_last    = (ptr_q == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         cfg_q    <= '0;
         ptr_q    <= '0;
      end else if (load_en) begin
         shadow_q <= shadow_nxt;
         if (at_last) begin
            cfg_q <= shadow_nxt;
            ptr_q <= '0;
         end else begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wxb_src_polarity.sv
module wxb_src_polarity #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic [NUM_SRC-1:0] src,
   input  logic [NUM_SRC-1:0] inv,
   output logic [NUM_SRC-1:0] pol
);

   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("wxb_src_polarity: need at least one source");
      end
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_bit
         assign pol[s] = src[s] ^ inv[s];
      end
   endgenerate

endmodule

// File: rtl/wxb_and_lane.sv
module wxb_and_lane #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned GROUP   = 8
) (
   input  logic [NUM_SRC-1:0] pol,
   input  logic [NUM_SRC-1:0] conn,
   output logic               y
);

   localparam int unsigned NG   = (NUM_SRC + GROUP - 1) / GROUP;
   localparam int unsigned PADW = NG * GROUP;

   logic [NUM_SRC-1:0] term;

   generate
      if (GROUP < 1) begin : g_bad_group
         $error("wxb_and_lane: group size must be positive");
      end
   endgenerate

   // An unconnected source contributes the AND identity.
   assign term = pol | ~conn;

   generate
      if (GROUP >= NUM_SRC) begin : g_flat
         assign y = &term;
      end else begin : g_tree
         logic [PADW-1:0] padded;
         logic [NG-1:0]   partial;
         always_comb begin
            padded                = '1;
            padded[NUM_SRC-1:0]   = term;
         end
         for (genvar g = 0; g < NG; g++) begin : g_grp
            assign partial[g] = &padded[g*GROUP +: GROUP];
         end
         assign y = &partial;
      end
   endgenerate

endmodule

// File: rtl/wired_and_xbar.sv
module wired_and_xbar
   import wxb_pkg::*;
#(
   parameter int unsigned NUM_MC    = 12,
   parameter int unsigned NUM_IO    = 6,
   parameter int unsigned NUM_DED   = 2,
   parameter int unsigned NUM_BLK   = 4,
   parameter int unsigned BLK_IN    = 24,
   parameter bit          INVERT_EN = 1'b1,
   parameter int unsigned AND_GROUP = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_load_en,
   input  logic                       cfg_bit,
   input  logic [NUM_MC-1:0]          mc_i,
   input  logic [NUM_IO-1:0]          io_i,
   input  logic [NUM_DED-1:0]         ded_i,
   output logic [NUM_BLK*BLK_IN-1:0]  blk_in_o
);

   localparam int unsigned NUM_SRC  = NUM_MC + NUM_IO + NUM_DED;
   localparam int unsigned NUM_OUT  = NUM_BLK * BLK_IN;
   localparam int unsigned INV_BITS = inv_bit_count(NUM_SRC, INVERT_EN);
   localparam int unsigned TOTAL    = frame_len(NUM_SRC, NUM_OUT, INVERT_EN);
   localparam int unsigned CW       = ptr_width(TOTAL);

   generate
      if (NUM_MC < 1 || NUM_IO < 1 || NUM_DED < 1) begin : g_bad_groups
         $error("wired_and_xbar: every source group needs at least one member");
      end
      if (NUM_BLK < 1 || BLK_IN < 1) begin : g_bad_outs
         $error("wired_and_xbar: need at least one output");
      end
   endgenerate

   logic [TOTAL-1:0]   cfg_q;
   logic [CW-1:0]      ld_ptr;
   logic [NUM_SRC-1:0] src_vec;
   logic [NUM_SRC-1:0] inv_vec;
   logic [NUM_SRC-1:0] pol_vec;

   // Source index order: macrocells low, then I/O, then dedicated inputs.
   assign src_vec = {ded_i, io_i, mc_i};

   wxb_cfg_loader #(
      .TOTAL (TOTAL),
      .CW    (CW)
   ) u_loader (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (cfg_load_en),
      .cfg_bit (cfg_bit),
      .cfg_q   (cfg_q),
      .ptr_q   (ld_ptr)
   );

   generate
      if (INVERT_EN) begin : g_inv
         assign inv_vec = cfg_q[NUM_SRC-1:0];
      end else begin : g_noinv
         assign inv_vec = '0;
      end
   endgenerate

   wxb_src_polarity #(
      .NUM_SRC (NUM_SRC)
   ) u_pol (
      .src (src_vec),
      .inv (inv_vec),
      .pol (pol_vec)
   );

   generate
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_lane
         wxb_and_lane #(
            .NUM_SRC (NUM_SRC),
            .GROUP   (AND_GROUP)
         ) u_lane (
            .pol  (pol_vec),
            .conn (cfg_q[INV_BITS + o*NUM_SRC +: NUM_SRC]),
            .y    (blk_in_o[o])
         );
      end
   endgenerate

endmodule

// File: rtl/wxb_chk.sv
module wxb_chk #(
   parameter int unsigned NUM_SRC  = 8,
   parameter int unsigned NUM_OUT  = 8,
   parameter int unsigned INV_BITS = 8,
   parameter int unsigned TOTAL    = 72,
   parameter int unsigned CW       = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               load_en,
   input logic [CW-1:0]      ptr,
   input logic [TOTAL-1:0]   cfg_active,
   input logic [NUM_OUT-1:0] out
);

   localparam logic [CW-1:0] LAST_POS = CW'(TOTAL - 1);

   AST_IDLE_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(cfg_active) && $stable(ptr)) else $error("idle load changed state"); // R7

   AST_PARTIAL_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && ptr != LAST_POS) |=> $stable(cfg_active)) else $error("early commit"); // R6

   AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && ptr != LAST_POS) |=> ptr == CW'($past(ptr) + 1'b1)) else $error("pointer skipped"); // R5

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && ptr == LAST_POS) |=> ptr == '0) else $error("pointer did not wrap"); // R6

   always_comb begin
      for (int o = 0; o < NUM_OUT; o++) begin
         if (rst_n && (cfg_active[INV_BITS + o*NUM_SRC +: NUM_SRC] == '0)) begin
            AST_EMPTY_LANE_HIGH: assert (out[o] == 1'b1) else $error("empty lane low"); // R2
         end
      end
   end

endmodule

bind wired_and_xbar wxb_chk #(
   .NUM_SRC  (NUM_SRC),
   .NUM_OUT  (NUM_OUT),
   .INV_BITS (INV_BITS),
   .TOTAL    (TOTAL),
   .CW       (CW)
) u_wxb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_en    (cfg_load_en),
   .ptr        (ld_ptr),
   .cfg_active (cfg_q),
   .out        (blk_in_o)
);

// File: tb/wired_and_xbar_bench.sv
`timescale 1ns/1ps
module wired_and_xbar_bench;

   localparam int NS  = 7;
   localparam int NO  = 6;
   localparam int TOT = NS + NS * NO;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_load_en = 1'b0;
   logic          cfg_bit = 1'b0;
   logic [NS-1:0] srcv = '0;
   logic [NO-1:0] dut_out;

   int checks = 0;
   int errors = 0;

   bit a_conn [NO][NS];
   bit a_inv  [NS];
   bit p_conn [NO][NS];
   bit p_inv  [NS];
   bit stream [TOT];
   int unsigned lcg = 32'h1234_5678;

   always #2 clk = ~clk;

   wired_and_xbar #(
      .NUM_MC(3), .NUM_IO(2), .NUM_DED(2),
      .NUM_BLK(2), .BLK_IN(3), .INVERT_EN(1'b1), .AND_GROUP(3)
   ) u_wired_and_xbar (
      .clk(clk), .rst_n(rst_n), .cfg_load_en(cfg_load_en), .cfg_bit(cfg_bit),
      .mc_i(srcv[2:0]), .io_i(srcv[4:3]), .ded_i(srcv[6:5]),
      .blk_in_o(dut_out)
   );

   function automatic logic [NO-1:0] model(input logic [NS-1:0] sv);
      logic [NO-1:0] r;
      for (int o = 0; o < NO; o++) begin
         r[o] = 1'b1;
         for (int s = 0; s < NS; s++)
            if (a_conn[o][s]) r[o] = r[o] & (sv[s] ^ a_inv[s]);
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic clear_pending();
      for (int o = 0; o < NO; o++) for (int s = 0; s < NS; s++) p_conn[o][s] = 1'b0;
      for (int s = 0; s < NS; s++) p_inv[s] = 1'b0;
   endtask

   task automatic build_stream();
      for (int s = 0; s < NS; s++) stream[s] = p_inv[s];
      for (int o = 0; o < NO; o++)
         for (int s = 0; s < NS; s++) stream[NS + o*NS + s] = p_conn[o][s];
   endtask

   task automatic commit_model();
      for (int o = 0; o < NO; o++) for (int s = 0; s < NS; s++) a_conn[o][s] = p_conn[o][s];
      for (int s = 0; s < NS; s++) a_inv[s] = p_inv[s];
   endtask

   task automatic send_range(input int lo, input int hi);
      for (int i = lo; i < hi; i++) begin
         @(negedge clk);
         cfg_load_en = 1'b1;
         cfg_bit = stream[i];
      end
      @(negedge clk);
      cfg_load_en = 1'b0;
   endtask

   task automatic load_full();
      build_stream();
      send_range(0, TOT);
      commit_model();
   endtask

   task automatic sweep(input string req);
      for (int v = 0; v < (1 << NS); v++) begin
         @(negedge clk);
         srcv = NS'(v);
         #1 chk(req, dut_out, model(NS'(v)));
      end
   endtask

   function automatic bit rnd(input int pct);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return ((lcg >> 16) % 100) < pct;
   endfunction

   initial begin
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      clear_pending();
      commit_model();
      srcv = '1;
      #5 chk("R1 in reset", dut_out, '1);
      @(negedge clk);
      rst_n = 1'b1;
      sweep("R1 R2 empty lanes after reset");

      // R3 R5: rotated single connections cover every pair
      for (int k = 0; k < NS; k++) begin
         clear_pending();
         for (int o = 0; o < NO; o++) p_conn[o][(k + o) % NS] = 1'b1;
         load_full();
         sweep("R3 R5 single routes");
      end

      // R4: wide NOR on output 0, single inverted route on output 1
      clear_pending();
      for (int s = 0; s < NS; s++) begin p_conn[0][s] = 1'b1; p_inv[s] = 1'b1; end
      p_conn[1][2] = 1'b1;
      load_full();
      for (int v = 0; v < (1 << NS); v++) begin
         @(negedge clk);
         srcv = NS'(v);
         #1 chk("R4 NOR and inverted route", dut_out,
                {4'b1111, ~srcv[2], (v == 0) ? 1'b1 : 1'b0});
      end

      // R2 R4: dense random maps with mixed polarity
      for (int k = 0; k < 5; k++) begin
         clear_pending();
         for (int o = 0; o < NO; o++) for (int s = 0; s < NS; s++) p_conn[o][s] = rnd(35);
         for (int s = 0; s < NS; s++) p_inv[s] = rnd(50);
         load_full();
         sweep("R2 R4 merged lanes");
      end

      // R6: all but the final bit keeps the old map; final bit switches
      clear_pending();
      for (int o = 0; o < NO; o++) p_conn[o][NS - 1 - (o % NS)] = 1'b1;
      p_inv[0] = 1'b1;
      build_stream();
      send_range(0, TOT - 1);
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         srcv = NS'(v * 9);
         #1 chk("R6 before final bit", dut_out, model(NS'(v * 9)));
      end
      send_range(TOT - 1, TOT);
      commit_model();
      sweep("R6 after final bit");

      // R7: pause mid-frame with cfg_bit toggling, then resume
      clear_pending();
      for (int o = 0; o < NO; o++) begin p_conn[o][o] = 1'b1; p_conn[o][6] = 1'b1; end
      p_inv[6] = 1'b1;
      build_stream();
      send_range(0, 20);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         cfg_bit = i[0];
         srcv = NS'(i * 17);
         #1 chk("R7 idle ignores cfg_bit", dut_out, model(NS'(i * 17)));
      end
      send_range(20, TOT);
      commit_model();
      sweep("R7 resumed load");

      // R8: outputs follow sources within a half cycle, no edge between
      @(posedge clk);
      #0.5 srcv = 7'b0000001;
      #0.5 chk("R8 combinational path", dut_out, model(7'b0000001));
      srcv = 7'b1000000;
      #0.5 chk("R8 combinational path", dut_out, model(7'b1000000));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule